// File: doc/BRIEF.md
# Configuration Access Routing Decoder

This block accepts one configuration access at a time (bus, device, function, register offset, direction and write data) and decides where it goes. The access goes to one of three places. An on-chip device on bus 0 takes it when that device is enabled and has function 0. The host bridge takes it when the bus number falls inside the bridge's secondary-to-subordinate window. Otherwise it is forwarded over the downstream chipset link as a Type 0 or Type 1 configuration packet. Claiming is subtractive: whatever the internal devices and the bridge leave over goes downstream.

The decision is registered and offered on a ready/valid route port one clock after the request is accepted. A forwarded access then waits for the downstream completion. If nothing downstream claimed it, the block turns it into a master abort: a read returns all ones, and a write is dropped but still completes. The controller has four states. ST_IDLE waits for a request. ST_ROUTE offers the decision. ST_WAIT_DN waits for the downstream completion. ST_CPL offers the completion.

The transitions are:
- T_ACCEPT: ST_IDLE to ST_ROUTE on a request handshake.
- T_ISSUE_LOCAL: ST_ROUTE to ST_IDLE when an internal or bridge decision is taken.
- T_CHAIN: ST_ROUTE to ST_ROUTE when such a decision is taken and a new request is accepted in the same cycle.
- T_ISSUE_DOWN: ST_ROUTE to ST_WAIT_DN when a downstream decision is taken.
- T_DN_DONE: ST_WAIT_DN to ST_CPL on the downstream completion.
- T_RETIRE: ST_CPL to ST_IDLE on the completion handshake.
- T_RETIRE_CHAIN: ST_CPL to ST_ROUTE when the completion handshake and a new request handshake fall in the same cycle.

Top module: `cfg_route_decoder`

## Requirements
- R1: A request with bus 0 and device d below NDEV, where dev_enable[d] and fn0_present[d] are both 1, is routed with route code 0 (internal) and type bit 0, whatever its function number.
- R2: A bus-0 request to a device that is disabled, lacks function 0, or is numbered NDEV or above is routed with route code 2 (downstream) and type bit 0 (Type 0).
- R3: A request with a non-zero bus B where sec_bus <= B <= sub_bus is routed with route code 1 (bridge). Its type bit is 0 when B equals sec_bus and 1 otherwise.
- R4: A request with a non-zero bus outside the bridge window is routed with route code 2 and type bit 1 (Type 1).
- R5: The decision appears on rt_valid one clock after the request handshake, carries the request's bus, device, function, offset, direction and write data, and stays stable until rt_ready is seen.
- R6: No new request is accepted while a decision is pending and rt_ready is low, or while a downstream completion is outstanding.
- R7: A downstream read that nobody claims completes with cpl_abort 1 and data 0xFFFFFFFF.
- R8: A downstream write that nobody claims completes with cpl_abort 1 and data 0.
- R9: A claimed downstream read completes with cpl_abort 0 and the returned data. A claimed write completes with cpl_abort 0 and data 0.
- R10: When a completion handshake and a new request handshake fall in the same cycle, the completion retires and the new decision appears one clock later.
- R11: During and right after reset, req_ready is 1 and rt_valid, dn_cpl_ready and cpl_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_enable | input | NDEV | Per-device enable, bit d for device d |
| fn0_present | input | NDEV | Per-device function-0-present flag |
| sec_bus | input | BUS_W | Bridge secondary bus number |
| sub_bus | input | BUS_W | Bridge subordinate bus number |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_bus | input | BUS_W | Request bus number |
| req_dev | input | DEV_W | Request device number |
| req_fn | input | FN_W | Request function number |
| req_reg | input | REG_W | Request register offset |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | DATA_W | Write data |
| rt_valid | output | 1 | Route decision valid |
| rt_ready | input | 1 | Route decision taken |
| rt_route | output | 2 | 0 internal, 1 bridge, 2 downstream |
| rt_type | output | 1 | 0 Type 0 packet, 1 Type 1 packet |
| rt_bus | output | BUS_W | Target bus |
| rt_dev | output | DEV_W | Target device |
| rt_fn | output | FN_W | Target function |
| rt_reg | output | REG_W | Target register offset |
| rt_write | output | 1 | Target direction |
| rt_wdata | output | DATA_W | Target write data |
| dn_cpl_valid | input | 1 | Downstream completion valid |
| dn_cpl_ready | output | 1 | Downstream completion accepted |
| dn_cpl_claimed | input | 1 | 1 if a downstream device claimed the access |
| dn_cpl_rdata | input | DATA_W | Downstream read data |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Completion taken |
| cpl_abort | output | 1 | Master abort flag |
| cpl_write | output | 1 | Direction of the completed access |
| cpl_rdata | output | DATA_W | Completion data |

## Verification
Retiring a downstream completion and accepting the next request can fall in the same cycle, because in ST_CPL the request ready follows cpl_ready. The bench holds a forwarded read in ST_CPL, then raises cpl_ready and req_valid together for a bridge-window request. It judges the cycle as correct if, one clock later, cpl_valid is low and the new decision is on rt_valid with the new target and route code. The same overlap between a taken local decision and a fresh request is covered by the T_CHAIN path and its assertion.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

    typedef enum logic [1:0] {
        ROUTE_INTERNAL   = 2'd0,
        ROUTE_BRIDGE     = 2'd1,
        ROUTE_DOWNSTREAM = 2'd2
    } route_e;

    typedef enum logic {
        PKT_TYPE0 = 1'b0,
        PKT_TYPE1 = 1'b1
    } pkt_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ROUTE   = 2'd1,
        ST_WAIT_DN = 2'd2,
        ST_CPL     = 2'd3
    } state_e;

endpackage

// File: rtl/cfg_claim_decode.sv
module cfg_claim_decode
    import cfg_route_pkg::*;
#(
    parameter int NDEV  = 8,
    parameter int BUS_W = 8,
    parameter int DEV_W = 5
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [NDEV-1:0]  dev_enable,
    input  logic [NDEV-1:0]  fn0_present,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output route_e           route,
    output pkt_e             ptype
);

    logic [NDEV-1:0] dev_hit;
    logic            bus_zero;
    logic            internal_claim;
    logic            in_window;

    // One comparator per on-chip device slot.
    for (genvar g = 0; g < NDEV; g++) begin : g_slot
        assign dev_hit[g] = (int'(dev) == g) && dev_enable[g] && fn0_present[g];
    end

    assign bus_zero       = (bus == '0);
    assign internal_claim = bus_zero && (|dev_hit);
    assign in_window      = !bus_zero && (bus >= sec_bus) && (bus <= sub_bus);

    always_comb begin
        if (internal_claim) begin
            route = ROUTE_INTERNAL;
            ptype = PKT_TYPE0;
        end else if (in_window) begin
            route = ROUTE_BRIDGE;
            ptype = (bus == sec_bus) ? PKT_TYPE0 : PKT_TYPE1;
        end else begin
            route = ROUTE_DOWNSTREAM;
            ptype = bus_zero ? PKT_TYPE0 : PKT_TYPE1;
        end
    end

endmodule

// File: rtl/cfg_route_reg.sv
module cfg_route_reg
    import cfg_route_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5,
    parameter int FN_W   = 3,
    parameter int REG_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  route_e            route_in,
    input  pkt_e              ptype_in,
    input  logic [BUS_W-1:0]  bus_in,
    input  logic [DEV_W-1:0]  dev_in,
    input  logic [FN_W-1:0]   fn_in,
    input  logic [REG_W-1:0]  reg_in,
    input  logic              write_in,
    input  logic [DATA_W-1:0] wdata_in,
    output route_e            route_q,
    output pkt_e              ptype_q,
    output logic [BUS_W-1:0]  bus_q,
    output logic [DEV_W-1:0]  dev_q,
    output logic [FN_W-1:0]   fn_q,
    output logic [REG_W-1:0]  reg_q,
    output logic              write_q,
    output logic [DATA_W-1:0] wdata_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= ROUTE_INTERNAL;
            ptype_q <= PKT_TYPE0;
            bus_q   <= '0;
            dev_q   <= '0;
            fn_q    <= '0;
            reg_q   <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else if (load) begin
            route_q <= route_in;
            ptype_q <= ptype_in;
            bus_q   <= bus_in;
            dev_q   <= dev_in;
            fn_q    <= fn_in;
            reg_q   <= reg_in;
            write_q <= write_in;
            wdata_q <= wdata_in;
        end
    end

endmodule

// File: rtl/cfg_cpl_build.sv
module cfg_cpl_build #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              is_write,
    input  logic              claimed,
    input  logic [DATA_W-1:0] dn_rdata,
    output logic              abort_q,
    output logic [DATA_W-1:0] rdata_q
);

    logic [DATA_W-1:0] rdata_d;

    always_comb begin
        if (is_write)     rdata_d = '0;
        else if (claimed) rdata_d = dn_rdata;
        else              rdata_d = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abort_q <= 1'b0;
            rdata_q <= '0;
        end else if (load) begin
            abort_q <= !claimed;
            rdata_q <= rdata_d;
        end
    end

endmodule

// File: rtl/cfg_route_decoder.sv
module cfg_route_decoder
    import cfg_route_pkg::*;
#(
    parameter int NDEV   = 8,
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5,
    parameter int FN_W   = 3,
    parameter int REG_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NDEV-1:0]   dev_enable,
    input  logic [NDEV-1:0]   fn0_present,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_fn,
    input  logic [REG_W-1:0]  req_reg,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rt_valid,
    input  logic              rt_ready,
    output logic [1:0]        rt_route,
    output logic              rt_type,
    output logic [BUS_W-1:0]  rt_bus,
    output logic [DEV_W-1:0]  rt_dev,
    output logic [FN_W-1:0]   rt_fn,
    output logic [REG_W-1:0]  rt_reg,
    output logic              rt_write,
    output logic [DATA_W-1:0] rt_wdata,
    input  logic              dn_cpl_valid,
    output logic              dn_cpl_ready,
    input  logic              dn_cpl_claimed,
    input  logic [DATA_W-1:0] dn_cpl_rdata,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic              cpl_abort,
    output logic              cpl_write,
    output logic [DATA_W-1:0] cpl_rdata
);

    state_e state_q, state_d;
    route_e dec_route, held_route;
    pkt_e   dec_type, held_type;
    logic   req_fire, rt_fire, dn_fire, cpl_fire, held_is_dn;

    cfg_claim_decode #(.NDEV(NDEV), .BUS_W(BUS_W), .DEV_W(DEV_W)) u_decode (
        .bus         (req_bus),
        .dev         (req_dev),
        .dev_enable  (dev_enable),
        .fn0_present (fn0_present),
        .sec_bus     (sec_bus),
        .sub_bus     (sub_bus),
        .route       (dec_route),
        .ptype       (dec_type)
    );

    cfg_route_reg #(
        .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .REG_W(REG_W), .DATA_W(DATA_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (req_fire),
        .route_in (dec_route),
        .ptype_in (dec_type),
        .bus_in   (req_bus),
        .dev_in   (req_dev),
        .fn_in    (req_fn),
        .reg_in   (req_reg),
        .write_in (req_write),
        .wdata_in (req_wdata),
        .route_q  (held_route),
        .ptype_q  (held_type),
        .bus_q    (rt_bus),
        .dev_q    (rt_dev),
        .fn_q     (rt_fn),
        .reg_q    (rt_reg),
        .write_q  (rt_write),
        .wdata_q  (rt_wdata)
    );

    cfg_cpl_build #(.DATA_W(DATA_W)) u_cpl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dn_fire),
        .is_write (rt_write),
        .claimed  (dn_cpl_claimed),
        .dn_rdata (dn_cpl_rdata),
        .abort_q  (cpl_abort),
        .rdata_q  (cpl_rdata)
    );

    assign held_is_dn = (held_route == ROUTE_DOWNSTREAM);
    assign rt_route   = held_route;
    assign rt_type    = held_type;
    assign cpl_write  = rt_write;

    assign req_fire = req_valid && req_ready;
    assign rt_fire  = rt_valid && rt_ready;
    assign dn_fire  = dn_cpl_valid && dn_cpl_ready;
    assign cpl_fire = cpl_valid && cpl_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_fire) state_d = ST_ROUTE;               // T_ACCEPT
            end
            ST_ROUTE: begin
                if (rt_fire) begin
                    if (held_is_dn)    state_d = ST_WAIT_DN;    // T_ISSUE_DOWN
                    else if (req_fire) state_d = ST_ROUTE;      // T_CHAIN
                    else               state_d = ST_IDLE;       // T_ISSUE_LOCAL
                end
            end
            ST_WAIT_DN: begin
                if (dn_fire) state_d = ST_CPL;                  // T_DN_DONE
            end
            ST_CPL: begin
                if (cpl_fire) state_d = req_fire ? ST_ROUTE      // T_RETIRE_CHAIN
                                                 : ST_IDLE;      // T_RETIRE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready    = 1'b0;
        rt_valid     = 1'b0;
        dn_cpl_ready = 1'b0;
        cpl_valid    = 1'b0;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_ROUTE: begin
                rt_valid  = 1'b1;
                req_ready = rt_ready && !held_is_dn;
            end
            ST_WAIT_DN: dn_cpl_ready = 1'b1;
            ST_CPL: begin
                cpl_valid = 1'b1;
                req_ready = cpl_ready;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cfg_route_decoder_chk.sv
module cfg_route_decoder_chk #(
    parameter int BUS_W  = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_W-1:0]  sec_bus,
    input logic [BUS_W-1:0]  sub_bus,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rt_valid,
    input logic              rt_ready,
    input logic [1:0]        rt_route,
    input logic              rt_type,
    input logic [BUS_W-1:0]  rt_bus,
    input logic              dn_cpl_ready,
    input logic              cpl_valid,
    input logic              cpl_ready,
    input logic              cpl_abort,
    input logic              cpl_write,
    input logic [DATA_W-1:0] cpl_rdata
);

    p_internal_bus0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && rt_route == 2'd0) |-> (rt_bus == '0 && rt_type == 1'b0));

    p_down_type0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && rt_route == 2'd2 && rt_bus == '0) |-> (rt_type == 1'b0));

    p_bridge_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && rt_route == 2'd1) |-> (rt_bus >= sec_bus && rt_bus <= sub_bus && rt_bus != '0));

    p_down_type1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && rt_route == 2'd2 && rt_bus != '0) |-> (rt_type == 1'b1));

    p_accept_to_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rt_valid);

    p_route_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && !rt_ready) |=> (rt_valid && $stable(rt_route) && $stable(rt_type) && $stable(rt_bus)));

    p_no_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((rt_valid && !rt_ready) || dn_cpl_ready) |-> !req_ready);

    p_abort_read_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_abort && !cpl_write) |-> (cpl_rdata == '1));

    p_abort_write_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_write) |-> (cpl_rdata == '0));

    p_cpl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_rdata) && $stable(cpl_abort)));

    p_retire_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready && req_valid && req_ready) |=> (rt_valid && !cpl_valid));

    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rt_valid, dn_cpl_ready, cpl_valid}));

endmodule

bind cfg_route_decoder cfg_route_decoder_chk #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sec_bus      (sec_bus),
    .sub_bus      (sub_bus),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rt_valid     (rt_valid),
    .rt_ready     (rt_ready),
    .rt_route     (rt_route),
    .rt_type      (rt_type),
    .rt_bus       (rt_bus),
    .dn_cpl_ready (dn_cpl_ready),
    .cpl_valid    (cpl_valid),
    .cpl_ready    (cpl_ready),
    .cpl_abort    (cpl_abort),
    .cpl_write    (cpl_write),
    .cpl_rdata    (cpl_rdata)
);

// File: tb/cfg_route_decoder_bench.sv
module cfg_route_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dev_enable  = 8'b1011_0111;
    logic [7:0]  fn0_present = 8'b1111_1011;
    logic [7:0]  sec_bus = 8'd4;
    logic [7:0]  sub_bus = 8'd9;
    logic        req_valid = 1'b0, req_ready;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_fn = '0;
    logic [11:0] req_reg = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rt_valid, rt_ready = 1'b0;
    logic [1:0]  rt_route;
    logic        rt_type;
    logic [7:0]  rt_bus;
    logic [4:0]  rt_dev;
    logic [2:0]  rt_fn;
    logic [11:0] rt_reg;
    logic        rt_write;
    logic [31:0] rt_wdata;
    logic        dn_cpl_valid = 1'b0, dn_cpl_ready;
    logic        dn_cpl_claimed = 1'b0;
    logic [31:0] dn_cpl_rdata = '0;
    logic        cpl_valid, cpl_ready = 1'b0;
    logic        cpl_abort, cpl_write;
    logic [31:0] cpl_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cfg_route_decoder u_cfg_route_decoder (.*);

    typedef struct packed {
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic        wr;
        logic [1:0]  route;
        logic        ptype;
        logic        claim;
        logic [31:0] data;
    } vec_t;

    // route: 0 internal, 1 bridge, 2 downstream
    localparam vec_t VECS [0:13] = '{
        '{8'd0,   5'd0,  3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0},        // R1
        '{8'd0,   5'd1,  3'd5, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0},        // R1 other fn
        '{8'd0,   5'd7,  3'd0, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0},        // R1
        '{8'd0,   5'd2,  3'd0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0},        // R2 no fn0, R7
        '{8'd0,   5'd2,  3'd3, 1'b0, 2'd2, 1'b0, 1'b1, 32'hCAFE0001}, // R2, R9
        '{8'd0,   5'd3,  3'd0, 1'b1, 2'd2, 1'b0, 1'b0, 32'h0},        // R2 disabled, R8
        '{8'd0,   5'd12, 3'd0, 1'b1, 2'd2, 1'b0, 1'b1, 32'h0},        // R2 off-chip, R9
        '{8'd0,   5'd6,  3'd1, 1'b0, 2'd2, 1'b0, 1'b1, 32'h12345678}, // R2 disabled
        '{8'd4,   5'd0,  3'd0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0},        // R3 secondary
        '{8'd5,   5'd3,  3'd1, 1'b1, 2'd1, 1'b1, 1'b0, 32'h0},        // R3
        '{8'd9,   5'd0,  3'd0, 1'b0, 2'd1, 1'b1, 1'b0, 32'h0},        // R3 subordinate
        '{8'd3,   5'd0,  3'd0, 1'b0, 2'd2, 1'b1, 1'b0, 32'h0},        // R4 below
        '{8'd10,  5'd1,  3'd0, 1'b1, 2'd2, 1'b1, 1'b0, 32'h0},        // R4 above, R8
        '{8'd255, 5'd31, 3'd7, 1'b0, 2'd2, 1'b1, 1'b1, 32'hA5A5A5A5}  // R4, R9
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic present(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                           input logic w, input logic [31:0] wd);
        req_bus = b; req_dev = d; req_fn = f; req_write = w; req_wdata = wd;
        req_reg = {4'h0, b} ^ 12'h0A4;
        req_valid = 1'b1;
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        logic [31:0] exp_data;
        @(negedge clk);
        present(v.bus, v.dev, v.fn, v.wr, 32'hD000_0000 | 32'(v.bus));
        @(negedge clk);
        req_valid = 1'b0;
        check(rt_valid == 1'b1, {tag, " R5 valid"}, 32'(rt_valid), 32'd1);
        check(rt_route == v.route, {tag, " route"}, 32'(rt_route), 32'(v.route));
        check(rt_type == v.ptype, {tag, " type"}, 32'(rt_type), 32'(v.ptype));
        check(rt_bus == v.bus && rt_dev == v.dev && rt_fn == v.fn && rt_write == v.wr,
              {tag, " R5 target"}, {8'h0, rt_bus, 5'h0, rt_dev, 5'h0, rt_fn},
              {8'h0, v.bus, 5'h0, v.dev, 5'h0, v.fn});
        check(rt_wdata == (32'hD000_0000 | 32'(v.bus)), {tag, " R5 wdata"}, rt_wdata,
              32'hD000_0000 | 32'(v.bus));
        rt_ready = 1'b1;
        @(negedge clk);
        rt_ready = 1'b0;
        if (v.route == 2'd2) begin
            check(dn_cpl_ready == 1'b1 && req_ready == 1'b0, {tag, " R6 waiting"},
                  {30'h0, dn_cpl_ready, req_ready}, 32'h2);
            dn_cpl_valid = 1'b1; dn_cpl_claimed = v.claim; dn_cpl_rdata = v.data;
            @(negedge clk);
            dn_cpl_valid = 1'b0;
            exp_data = v.wr ? 32'h0 : (v.claim ? v.data : 32'hFFFF_FFFF);
            check(cpl_valid == 1'b1, {tag, " cpl valid"}, 32'(cpl_valid), 32'd1);
            check(cpl_abort == !v.claim, {tag, " R7/R8/R9 abort"}, 32'(cpl_abort), 32'(!v.claim));
            check(cpl_rdata == exp_data, {tag, " R7/R8/R9 data"}, cpl_rdata, exp_data);
            cpl_ready = 1'b1;
            @(negedge clk);
            cpl_ready = 1'b0;
            check(cpl_valid == 1'b0, {tag, " cpl retired"}, 32'(cpl_valid), 32'd0);
        end else begin
            check(rt_valid == 1'b0 && req_ready == 1'b1, {tag, " local done"},
                  {30'h0, rt_valid, req_ready}, 32'h1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        @(negedge clk);
        check(req_ready && !rt_valid && !dn_cpl_ready && !cpl_valid, "R11 in reset",
              {28'h0, req_ready, rt_valid, dn_cpl_ready, cpl_valid}, 32'h8);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rt_valid && !dn_cpl_ready && !cpl_valid, "R11 after reset",
              {28'h0, req_ready, rt_valid, dn_cpl_ready, cpl_valid}, 32'h8);

        // Vector table: R1 R2 R3 R4 R7 R8 R9
        for (int i = 0; i < 14; i++) run_vec(VECS[i], $sformatf("vec%0d", i));

        // R5 / R6: decision held while rt_ready low, no second accept
        @(negedge clk);
        present(8'd6, 5'd2, 3'd0, 1'b0, 32'h0);
        @(negedge clk);
        present(8'd0, 5'd0, 3'd0, 1'b0, 32'h0);
        for (int k = 0; k < 3; k++) begin
            check(req_ready == 1'b0, "R6 busy", 32'(req_ready), 32'd0);
            check(rt_valid && rt_bus == 8'd6 && rt_route == 2'd1 && rt_type == 1'b1,
                  "R5 hold", {22'h0, rt_valid, rt_bus, rt_route, rt_type}, {22'h0, 1'b1, 8'd6, 2'd1, 1'b1});
            @(negedge clk);
        end
        req_valid = 1'b0;
        rt_ready = 1'b1;
        @(negedge clk);
        rt_ready = 1'b0;
        check(!rt_valid && req_ready, "R6 single decision", {30'h0, rt_valid, req_ready}, 32'h1);

        // R10: retire completion and accept new request in one cycle
        @(negedge clk);
        present(8'd20, 5'd0, 3'd0, 1'b0, 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        rt_ready = 1'b1;
        @(negedge clk);
        rt_ready = 1'b0;
        dn_cpl_valid = 1'b1; dn_cpl_claimed = 1'b0;
        @(negedge clk);
        dn_cpl_valid = 1'b0;
        check(cpl_valid && cpl_abort && cpl_rdata == 32'hFFFF_FFFF, "R7 before chain", cpl_rdata, 32'hFFFF_FFFF);
        present(8'd4, 5'd1, 3'd2, 1'b0, 32'h0);
        check(req_ready == 1'b0, "R10 ready follows cpl_ready", 32'(req_ready), 32'd0);
        cpl_ready = 1'b1;
        #1;
        check(req_ready == 1'b1, "R10 ready with cpl_ready", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0; cpl_ready = 1'b0;
        check(!cpl_valid && rt_valid, "R10 retire and route", {30'h0, cpl_valid, rt_valid}, 32'h1);
        check(rt_route == 2'd1 && rt_type == 1'b0 && rt_dev == 5'd1 && rt_fn == 3'd2,
              "R10 new target R3", {24'h0, rt_route, rt_type, rt_dev}, {24'h0, 2'd1, 1'b0, 5'd1});
        rt_ready = 1'b1;
        @(negedge clk);
        rt_ready = 1'b0;
        check(!rt_valid && req_ready, "R10 back to idle", {30'h0, rt_valid, req_ready}, 32'h1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule